// File: doc/BRIEF.md
# Punctured-Code Rate Acquisition Controller

This block finds the operating point of a punctured convolutional decoder: the code rate, the puncture synchronization phase and the two-way carrier phase ambiguity. Once the demodulator reports lock, it steers the depuncturer and the branch-metric stage through a fixed list of hypotheses. Each hypothesis is held for a dwell window of a fixed number of symbols. During the window the block counts the per-symbol traceback-convergence strobes.

A hypothesis is accepted when the convergence count reaches a programmable threshold by the end of its window. The controller then declares decoder lock and freezes the hypothesis. It keeps grading every later window. After a parameterized number of consecutive failing windows it drops lock and restarts the search. The soft I/Q samples never pass through this block. A host-written spectral-inversion bit is passed straight through to the down converter.

Top module: `rate_acq_ctrl`

## Requirements
- R1: While `demod_lock_i` is low, `lock_o` is 0, `rate_sel_o` is 3/4 (code 2), `punct_phase_o` is 0 and `carrier_flip_o` is 0, and no symbols are counted.
- R2: Rate codes are 0=1/2, 1=2/3, 2=3/4, 3=5/6, 4=7/8. The search starts at 3/4 and on exhausting a rate moves 3/4 to 2/3, 2/3 to 5/6, 5/6 to 7/8, and 7/8 to 1/2.
- R3: At each rate `punct_phase_o` steps 0, 1, … up to the phase count minus one. The phase counts are 1 for 1/2, 2 for 2/3, 3 for 3/4, 5 for 5/6 and 7 for 7/8.
- R4: At each rate and phase, `carrier_flip_o` is tried at 0 and then at 1 before the phase advances.
- R5: A window spans `DWELL_SYMS` cycles with `sym_valid_i` high. `conv_i` counts only in those cycles. A window passes when its count is at least `thresh_i`, an equal count included. The outputs react on the clock edge after the window's last symbol edge.
- R6: A passing window during search raises `lock_o` and leaves the hypothesis unchanged for as long as lock holds.
- R7: A failed window at rate 1/2 returns the search to rate 3/4, phase 0, carrier flip 0.
- R8: While locked, a passing window clears the miss count. `LOSS_WINDOWS` consecutive failing windows drop `lock_o` and restart the search from the first hypothesis.
- R9: Lowering `demod_lock_i` clears `lock_o` and resets the hypothesis on the next clock edge. The search resumes only one cycle after the input is raised again.
- R10: `spec_inv_o` follows `spec_inv_i` combinationally in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| demod_lock_i | input | 1 | Demodulator carrier lock |
| sym_valid_i | input | 1 | One decoded symbol this cycle |
| conv_i | input | 1 | Traceback converged on this symbol |
| thresh_i | input | CNT_W | Convergences required per window |
| spec_inv_i | input | 1 | Host spectral-inversion control |
| rate_sel_o | output | 3 | Code rate under test |
| punct_phase_o | output | 3 | Puncture phase under test |
| carrier_flip_o | output | 1 | Carrier ambiguity hypothesis |
| spec_inv_o | output | 1 | Spectral-inversion control to down converter |
| lock_o | output | 1 | Decoder lock |

## Verification
A wrong window or miss count in this block is never visible at the ports by itself. It shows up as a hypothesis step, a lock rise or a lock drop that lands one or more windows early or late. It also shows up as a step taken at the wrong symbol edge. The bench therefore tracks every window boundary in its own model and compares all outputs on every cycle. A wrong ordering in the hypothesis sequencer is caught at the first window boundary it affects.

// File: rtl/rate_acq_pkg.sv
package rate_acq_pkg;
  localparam int PH_W = 3;

  typedef enum logic [2:0] {
    RATE_1_2 = 3'd0,
    RATE_2_3 = 3'd1,
    RATE_3_4 = 3'd2,
    RATE_5_6 = 3'd3,
    RATE_7_8 = 3'd4
  } rate_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_LOCKED} acq_st_e;

  localparam rate_e FIRST_RATE = RATE_3_4;

  function automatic logic [PH_W-1:0] phase_count(rate_e r);
    case (r)
      RATE_2_3: phase_count = PH_W'(2);
      RATE_3_4: phase_count = PH_W'(3);
      RATE_5_6: phase_count = PH_W'(5);
      RATE_7_8: phase_count = PH_W'(7);
      default:  phase_count = PH_W'(1);
    endcase
  endfunction

  function automatic rate_e next_rate(rate_e r);
    case (r)
      RATE_3_4: next_rate = RATE_2_3;
      RATE_2_3: next_rate = RATE_5_6;
      RATE_5_6: next_rate = RATE_7_8;
      RATE_7_8: next_rate = RATE_1_2;
      default:  next_rate = RATE_3_4;
    endcase
  endfunction
endpackage

// File: rtl/acq_window.sv
module acq_window #(
  parameter int DWELL_SYMS = 256,
  parameter int CNT_W      = $clog2(DWELL_SYMS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sym_valid_i,
  input  logic             conv_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             win_end_o,
  output logic             win_pass_o
);
  localparam int SYM_W = (DWELL_SYMS > 1) ? $clog2(DWELL_SYMS) : 1;

  logic [SYM_W-1:0] sym_q;
  logic [CNT_W-1:0] conv_q, conv_sum;
  logic             last_sym;

  assign conv_sum   = conv_q + CNT_W'(conv_i);
  assign last_sym   = (sym_q == SYM_W'(DWELL_SYMS - 1));
  assign win_end_o  = sym_valid_i & last_sym & ~clear_i;
  assign win_pass_o = (conv_sum >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= '0;
      conv_q <= '0;
    end else if (clear_i) begin
      sym_q  <= '0;
      conv_q <= '0;
    end else if (sym_valid_i) begin
      if (last_sym) begin
        sym_q  <= '0;
        conv_q <= '0;
      end else begin
        sym_q  <= sym_q + SYM_W'(1);
        conv_q <= conv_sum;
      end
    end
  end
endmodule

// File: rtl/acq_hyp_seq.sv
module acq_hyp_seq
  import rate_acq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            advance_i,
  output rate_e           rate_o,
  output logic [PH_W-1:0] phase_o,
  output logic            flip_o
);
  rate_e           rate_q;
  logic [PH_W-1:0] phase_q;
  logic            flip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= FIRST_RATE;
      phase_q <= '0;
      flip_q  <= 1'b0;
    end else if (restart_i) begin
      rate_q  <= FIRST_RATE;
      phase_q <= '0;
      flip_q  <= 1'b0;
    end else if (advance_i) begin
      // carrier ambiguity is the innermost loop, then phase, then rate
      flip_q <= ~flip_q;
      if (flip_q) begin
        if (phase_q == phase_count(rate_q) - PH_W'(1)) begin
          phase_q <= '0;
          rate_q  <= next_rate(rate_q);
        end else begin
          phase_q <= phase_q + PH_W'(1);
        end
      end
    end
  end

  assign rate_o  = rate_q;
  assign phase_o = phase_q;
  assign flip_o  = flip_q;
endmodule

// File: rtl/acq_lock_fsm.sv
module acq_lock_fsm
  import rate_acq_pkg::*;
#(
  parameter int LOSS_WINDOWS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic demod_lock_i,
  input  logic win_end_i,
  input  logic win_pass_i,
  output logic clear_o,
  output logic advance_o,
  output logic restart_o,
  output logic lock_o
);
  localparam int MISS_W = $clog2(LOSS_WINDOWS + 1);

  acq_st_e           st_q, st_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              win_fail, loss;

  assign win_fail = win_end_i & ~win_pass_i;
  assign loss     = (st_q == ST_LOCKED) & win_fail & (miss_q == MISS_W'(LOSS_WINDOWS - 1));

  always_comb begin
    st_d   = st_q;
    miss_d = miss_q;
    if (!demod_lock_i) begin
      st_d   = ST_IDLE;
      miss_d = '0;
    end else begin
      case (st_q)
        ST_IDLE:   st_d = ST_SEARCH;
        ST_SEARCH: if (win_end_i && win_pass_i) st_d = ST_LOCKED;
        ST_LOCKED: begin
          if (loss) begin
            st_d   = ST_SEARCH;
            miss_d = '0;
          end else if (win_end_i) begin
            miss_d = win_pass_i ? '0 : miss_q + MISS_W'(1);
          end
        end
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      miss_q <= miss_d;
    end
  end

  assign clear_o   = ~demod_lock_i | (st_q == ST_IDLE);
  assign advance_o = demod_lock_i & (st_q == ST_SEARCH) & win_fail;
  assign restart_o = clear_o | loss;
  assign lock_o    = (st_q == ST_LOCKED);
endmodule

// File: rtl/rate_acq_ctrl.sv
module rate_acq_ctrl
  import rate_acq_pkg::*;
#(
  parameter int DWELL_SYMS   = 256,
  parameter int LOSS_WINDOWS = 4,
  parameter int CNT_W        = $clog2(DWELL_SYMS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             demod_lock_i,
  input  logic             sym_valid_i,
  input  logic             conv_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             spec_inv_i,
  output logic [2:0]       rate_sel_o,
  output logic [PH_W-1:0]  punct_phase_o,
  output logic             carrier_flip_o,
  output logic             spec_inv_o,
  output logic             lock_o
);
  logic  clear, win_end, win_pass, advance, restart;
  rate_e rate;

  acq_window #(.DWELL_SYMS(DWELL_SYMS), .CNT_W(CNT_W)) u_win (
    .clk_i, .rst_ni,
    .clear_i    (clear),
    .sym_valid_i,
    .conv_i,
    .thresh_i,
    .win_end_o  (win_end),
    .win_pass_o (win_pass)
  );

  acq_lock_fsm #(.LOSS_WINDOWS(LOSS_WINDOWS)) u_fsm (
    .clk_i, .rst_ni,
    .demod_lock_i,
    .win_end_i  (win_end),
    .win_pass_i (win_pass),
    .clear_o    (clear),
    .advance_o  (advance),
    .restart_o  (restart),
    .lock_o
  );

  acq_hyp_seq u_hyp (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .advance_i (advance),
    .rate_o    (rate),
    .phase_o   (punct_phase_o),
    .flip_o    (carrier_flip_o)
  );

  assign rate_sel_o = rate;
  assign spec_inv_o = spec_inv_i;
endmodule

// File: rtl/rate_acq_checker.sv
module rate_acq_checker
  import rate_acq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            demod_lock_i,
  input logic            spec_inv_i,
  input logic [2:0]      rate_sel_o,
  input logic [PH_W-1:0] punct_phase_o,
  input logic            carrier_flip_o,
  input logic            spec_inv_o,
  input logic            lock_o
);
  assert_idle_no_lock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !demod_lock_i |=> !lock_o);

  assert_rate_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_o != $past(rate_sel_o) && rate_sel_o != 3'(FIRST_RATE))
      |-> rate_sel_o == 3'(next_rate(rate_e'($past(rate_sel_o)))));

  assert_phase_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    punct_phase_o < phase_count(rate_e'(rate_sel_o)));

  assert_flip_before_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (punct_phase_o != $past(punct_phase_o) && punct_phase_o != '0) |-> $past(carrier_flip_o));

  assert_hyp_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |->
      ($stable(rate_sel_o) && $stable(punct_phase_o) && $stable(carrier_flip_o)));

  always_comb begin
    assert_spec_pass_R10: assert (spec_inv_o == spec_inv_i);
  end
endmodule

bind rate_acq_ctrl rate_acq_checker chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .demod_lock_i   (demod_lock_i),
  .spec_inv_i     (spec_inv_i),
  .rate_sel_o     (rate_sel_o),
  .punct_phase_o  (punct_phase_o),
  .carrier_flip_o (carrier_flip_o),
  .spec_inv_o     (spec_inv_o),
  .lock_o         (lock_o)
);

// File: tb/rate_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rate_acq_ctrl_tb_top;
  localparam int DW    = 8;
  localparam int LW    = 2;
  localparam int CW    = $clog2(DW + 1);
  localparam int T_R   = 3;   // target: rate 5/6, phase 4, flip 1
  localparam int T_P   = 4;
  localparam int T_F   = 1;
  localparam int WDOG  = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          demod = 1'b0, symv = 1'b0, conv = 1'b0, spec = 1'b0;
  logic [CW-1:0] thresh = CW'(5);
  logic [2:0]    rate_o, phase_o;
  logic          flip_o, spec_o, lock_o;

  int checks = 0, fails = 0, cyc = 0, mode = 0;
  // model state: 0 idle, 1 search, 2 locked
  int m_st = 0, m_rate = 2, m_ph = 0, m_fl = 0, m_sym = 0, m_cnt = 0, m_miss = 0;
  bit saw_wrap = 0;

  always #2.5 clk = ~clk;

  rate_acq_ctrl #(.DWELL_SYMS(DW), .LOSS_WINDOWS(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .demod_lock_i(demod), .sym_valid_i(symv),
    .conv_i(conv), .thresh_i(thresh), .spec_inv_i(spec),
    .rate_sel_o(rate_o), .punct_phase_o(phase_o), .carrier_flip_o(flip_o),
    .spec_inv_o(spec_o), .lock_o(lock_o));

  function automatic int b_nph(int r);
    case (r) 1: return 2; 2: return 3; 3: return 5; 4: return 7; default: return 1; endcase
  endfunction
  function automatic int b_next(int r);
    case (r) 2: return 1; 1: return 3; 3: return 4; 4: return 0; default: return 2; endcase
  endfunction

  task automatic m_home();
    m_rate = 2; m_ph = 0; m_fl = 0;
  endtask

  task automatic m_step_hyp();
    if (m_fl == 0) m_fl = 1;
    else begin
      m_fl = 0;
      if (m_ph == b_nph(m_rate) - 1) begin
        m_ph = 0;
        if (m_rate == 0) saw_wrap = 1;
        m_rate = b_next(m_rate);
      end else m_ph++;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_home(); m_sym = 0; m_cnt = 0; m_miss = 0;
    end else if (!demod) begin
      m_st = 0; m_home(); m_sym = 0; m_cnt = 0; m_miss = 0;
    end else if (m_st == 0) begin
      m_st = 1;
    end else if (symv) begin
      int c;
      c = m_cnt + int'(conv);
      if (m_sym == DW - 1) begin
        m_sym = 0; m_cnt = 0;
        if (m_st == 1) begin
          if (c >= int'(thresh)) begin m_st = 2; m_miss = 0; end
          else m_step_hyp();
        end else if (c >= int'(thresh)) m_miss = 0;
        else if (m_miss == LW - 1) begin m_st = 1; m_miss = 0; m_home(); end
        else m_miss++;
      end else begin
        m_sym++; m_cnt = c;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(int'(rate_o) == m_rate, "R1 R2 R7 rate_sel", int'(rate_o), m_rate);
    chk(int'(phase_o) == m_ph, "R1 R3 punct_phase", int'(phase_o), m_ph);
    chk(int'(flip_o) == m_fl, "R1 R4 carrier_flip", int'(flip_o), m_fl);
    chk(int'(lock_o) == int'(m_st == 2), "R5 R6 R8 R9 lock", int'(lock_o), int'(m_st == 2));
    chk(spec_o == spec, "R10 spec_inv", int'(spec_o), int'(spec));
  endtask

  // compare, then drive next inputs, all at the falling edge
  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
      cyc++;
      symv = (cyc % 3 != 2);
      spec = cyc[2];
      case (mode)
        1: conv = (m_rate == T_R && m_ph == T_P && m_fl == T_F);
        2: conv = 1'b1;
        3: conv = (m_sym != 0);
        default: conv = 1'b0;
      endcase
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: demod low, symbols and strobes present
    mode = 2;
    step(40);
    chk(lock_o == 1'b0 && rate_o == 3'd2, "R1 idle hold", int'(lock_o), 0);
    // R2 R3 R4 R7: full sweep with no convergence
    mode = 0; demod = 1'b1;
    step(560);
    chk(saw_wrap, "R7 wrap observed", int'(saw_wrap), 1);
    // R5 R6: only the target hypothesis converges
    mode = 1;
    for (int i = 0; i < 2000 && m_st != 2; i++) step(1);
    step(2);
    chk(lock_o && rate_o == 3'(T_R) && phase_o == 3'(T_P), "R6 lock at target",
        int'(phase_o), T_P);
    mode = 2; step(40);
    // R8: one failing window keeps lock, then two in a row drop it
    mode = 0; step(12);
    mode = 2; step(30);
    chk(lock_o == 1'b1, "R8 single miss tolerated", int'(lock_o), 1);
    mode = 0; step(60);
    chk(lock_o == 1'b0, "R8 lock dropped", int'(lock_o), 0);
    // R5 threshold boundary: 7 of 8 fails at thresh 8, 8 of 8 passes
    thresh = CW'(8); mode = 3; step(120);
    chk(lock_o == 1'b0, "R5 count below threshold", int'(lock_o), 0);
    mode = 2; step(30);
    chk(lock_o == 1'b1, "R5 count equal to threshold", int'(lock_o), 1);
    // R9: demod loss while locked
    demod = 1'b0; step(2);
    chk(lock_o == 1'b0 && rate_o == 3'd2 && phase_o == 3'd0, "R9 demod loss", int'(lock_o), 0);
    demod = 1'b1; step(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule